// File: doc/BRIEF.md
# Dual-Issue Decode and Dispatch

This block takes up to two 32-bit instructions per cycle from the fetch side. It decodes each one and gives each a reservation station from the pool its unit type uses. It then places the pair on two registered instruction buses. The functional units watch those buses. The first bit of each instruction picks the class. Memory operations use a short opcode, a register number and a word address. All other operations use a five-bit opcode that carries an explicit resource field and a function code. Because the resource field is explicit, the block can see in the same cycle when both instructions compete for the same pool.

Slot 0 of a pair is always the older instruction, and issue is in order. If slot 0 cannot issue, slot 1 waits even when its own unit is free. If both instructions need the same pool and only one station is free, the older one issues and the younger one stays in its slot until a station frees up. A full completion file stops all issue. Each station pool reports its state through a vector of free flags. A station given out in one cycle is treated as busy in the next decision cycle. This covers the cycle before the station's own free flag has had time to fall.

A new pair is latched when `in_rdy` is high. Its instructions appear on the buses on the second rising edge after that, provided nothing holds them. At full rate, one pair per cycle moves through.

Top module: `dual_dispatch`

## Requirements
- R1: After reset both bus valid flags are 0 and `in_rdy` is 1.
- R2: With bit 31 = 0, bits 30:29 give the resource: 00 is ALU (unit code 0), 01 is multiplier (unit code 1) and 10 is register file (unit code 2). Bits 28:27 are carried on the bus as the function code. Destination is bits 26:25, source 1 is bits 24:23, source 2 is bits 22:21 and the immediate is bits 15:0.
- R3: With bit 31 = 1, bit 30 = 1 is a load (unit code 3) and its destination is bits 29:28. Bit 30 = 0 is a store (unit code 4) and its source 1 is bits 29:28. The bus address is bits 27:0 followed by two zero bits.
- R4: A pair latched on a rising edge appears on buses 0 and 1 after the next rising edge. A new pair can be latched every cycle while resources are free.
- R5: An instruction takes the lowest-numbered free station of its pool. When both instructions of a pair use the same pool, the younger one takes the next free station above it.
- R6: When both instructions of a pair use the same pool and only one station is free, only the older instruction issues. The younger one is held and `in_rdy` stays 0 until it issues.
- R7: While the slot-0 instruction is held, the slot-1 instruction does not issue, even if its own pool has a free station.
- R8: While `cf_full` is 1, no instruction issues.
- R9: A bus slot that does not issue in a cycle drops its valid flag and keeps all of its other fields unchanged.
- R10: A station given out in one decision cycle is treated as busy in the next decision cycle, whatever its free flag says.
- R11: Register-file operations need no station. They issue with station tag 0 even when every free flag is 0.
- R12: A non-memory instruction with resource field 11 is dropped without a bus valid flag, and it does not hold back the instruction behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 2 | Valid flag for each incoming instruction; bit 0 is the older one |
| in_ins | input | 2x32 | Incoming instruction pair |
| in_rdy | output | 1 | The pair on the inputs is latched at the next rising edge |
| free_alu | input | NSTA | Free flags of the ALU stations |
| free_mul | input | NSTA | Free flags of the multiplier stations |
| free_ld | input | NSTA | Free flags of the load stations |
| free_st | input | NSTA | Free flags of the store stations |
| cf_full | input | 1 | Completion file has no free entry |
| bus_vld | output | 2 | Instruction bus valid flags |
| bus_unit | output | 2x3 | Unit code per bus |
| bus_fn | output | 2x2 | Function code per bus |
| bus_dst | output | 2x2 | Destination register per bus |
| bus_src1 | output | 2x2 | First source register per bus |
| bus_src2 | output | 2x2 | Second source register per bus |
| bus_sta | output | 2xSW | Allocated station index per bus |
| bus_imm | output | 2x16 | Immediate per bus |
| bus_addr | output | 2x30 | Byte address per bus |

## Verification
The bench drives several kinds of pair. Pairs with different units check field decoding and dual issue. Pairs of two loads or stores separate the load and store layouts and check the address shift. Pairs with the same pool, first with two free stations and then with one, separate correct station ranking from the conflict hold; the follow-up cycles show the claim mask, because a station that is still flagged free is skipped once. A held older instruction paired with a younger one whose unit is free, a full completion file, register-file pairs with every station busy, and a reserved resource code each isolate one rule for when an instruction may issue. Two pairs sent back to back confirm one pair per cycle.

// File: rtl/dd_pkg.sv
package dd_pkg;
  typedef enum logic [2:0] {
    U_ALU = 3'd0,
    U_MUL = 3'd1,
    U_RF  = 3'd2,
    U_LD  = 3'd3,
    U_ST  = 3'd4
  } unit_e;

  localparam int NPOOL = 4;
  localparam int P_ALU = 0;
  localparam int P_MUL = 1;
  localparam int P_LD  = 2;
  localparam int P_ST  = 3;

  typedef struct packed {
    logic        legal;
    logic        pooled;
    logic [1:0]  pool;
    unit_e       unit;
    logic [1:0]  fn;
    logic [1:0]  dst;
    logic [1:0]  s1;
    logic [1:0]  s2;
    logic [15:0] imm;
    logic [29:0] addr;
  } dec_t;
endpackage

// File: rtl/dd_decode.sv
module dd_decode
  import dd_pkg::*;
(
  input  logic [31:0] ins,
  output dec_t        d
);
  logic unused_pad;
  assign unused_pad = ^ins[20:16];

  always_comb begin
    d.legal  = 1'b0;
    d.pooled = 1'b0;
    d.pool   = 2'd0;
    d.unit   = U_ALU;
    d.fn     = 2'd0;
    d.dst    = 2'd0;
    d.s1     = 2'd0;
    d.s2     = 2'd0;
    d.imm    = 16'd0;
    d.addr   = 30'd0;
    if (ins[31]) begin
      d.legal  = 1'b1;
      d.pooled = 1'b1;
      d.addr   = {ins[27:0], 2'b00};
      if (ins[30]) begin
        d.unit = U_LD;
        d.pool = 2'(P_LD);
        d.dst  = ins[29:28];
      end else begin
        d.unit = U_ST;
        d.pool = 2'(P_ST);
        d.s1   = ins[29:28];
      end
    end else begin
      d.fn  = ins[28:27];
      d.dst = ins[26:25];
      d.s1  = ins[24:23];
      d.s2  = ins[22:21];
      d.imm = ins[15:0];
      case (ins[30:29])
        2'b00: begin d.legal = 1'b1; d.pooled = 1'b1; d.unit = U_ALU; d.pool = 2'(P_ALU); end
        2'b01: begin d.legal = 1'b1; d.pooled = 1'b1; d.unit = U_MUL; d.pool = 2'(P_MUL); end
        2'b10: begin d.legal = 1'b1; d.pooled = 1'b0; d.unit = U_RF; end
        default: d.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dd_pick.sv
module dd_pick #(
  parameter int N = 2,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] avail,
  output logic         ok1,
  output logic [W-1:0] idx1,
  output logic         ok2,
  output logic [W-1:0] idx2
);
  always_comb begin
    ok1  = 1'b0;
    idx1 = '0;
    ok2  = 1'b0;
    idx2 = '0;
    for (int i = 0; i < N; i++) begin
      if (avail[i]) begin
        if (!ok1) begin
          ok1  = 1'b1;
          idx1 = W'(i);
        end else if (!ok2) begin
          ok2  = 1'b1;
          idx2 = W'(i);
        end
      end
    end
  end

  // R5: the second choice always ranks above a valid first choice
  always_comb begin
    if (ok2) begin
      a_r5_second_above_first: assert (ok1 && (idx2 > idx1));
    end
  end
endmodule

// File: rtl/dd_bus_reg.sv
module dd_bus_reg
  import dd_pkg::*;
#(
  parameter int SW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  dec_t          d,
  input  logic [SW-1:0] sta,
  output logic          vld,
  output logic [2:0]    unit,
  output logic [1:0]    fn,
  output logic [1:0]    dst,
  output logic [1:0]    src1,
  output logic [1:0]    src2,
  output logic [SW-1:0] sta_q,
  output logic [15:0]   imm,
  output logic [29:0]   addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= 1'b0;
      unit  <= 3'd0;
      fn    <= 2'd0;
      dst   <= 2'd0;
      src1  <= 2'd0;
      src2  <= 2'd0;
      sta_q <= '0;
      imm   <= 16'd0;
      addr  <= 30'd0;
    end else begin
      vld <= issue;
      if (issue) begin
        unit  <= 3'(d.unit);
        fn    <= d.fn;
        dst   <= d.dst;
        src1  <= d.s1;
        src2  <= d.s2;
        sta_q <= sta;
        imm   <= d.imm;
        addr  <= d.addr;
      end
    end
  end

  // R9: an idle slot keeps its previous contents
  a_r9_idle_slot_stable: assert property (@(posedge clk) disable iff (rst)
    !vld |-> ($stable(unit) && $stable(dst) && $stable(src1) && $stable(src2) &&
              $stable(sta_q) && $stable(imm) && $stable(addr) && $stable(fn)));
endmodule

// File: rtl/dual_dispatch.sv
module dual_dispatch
  import dd_pkg::*;
#(
  parameter int NSTA = 2,
  localparam int SW = (NSTA > 1) ? $clog2(NSTA) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            in_vld,
  input  logic [1:0][31:0]      in_ins,
  output logic                  in_rdy,
  input  logic [NSTA-1:0]       free_alu,
  input  logic [NSTA-1:0]       free_mul,
  input  logic [NSTA-1:0]       free_ld,
  input  logic [NSTA-1:0]       free_st,
  input  logic                  cf_full,
  output logic [1:0]            bus_vld,
  output logic [1:0][2:0]       bus_unit,
  output logic [1:0][1:0]       bus_fn,
  output logic [1:0][1:0]       bus_dst,
  output logic [1:0][1:0]       bus_src1,
  output logic [1:0][1:0]       bus_src2,
  output logic [1:0][SW-1:0]    bus_sta,
  output logic [1:0][15:0]      bus_imm,
  output logic [1:0][29:0]      bus_addr
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0]             pv;
  logic [NSLOT-1:0][31:0]       pins;
  dec_t                         dec [NSLOT];
  logic [NPOOL-1:0][NSTA-1:0]   free_raw;
  logic [NPOOL-1:0][NSTA-1:0]   mask_q;
  logic [NPOOL-1:0][NSTA-1:0]   alloc_d;
  logic [NPOOL-1:0]             ok1, ok2;
  logic [NPOOL-1:0][SW-1:0]     idx1, idx2;
  logic                         share, res0, res1, go0, go1, done0;
  logic [NSLOT-1:0]             iss;
  logic [NSLOT-1:0][SW-1:0]     sta;

  assign free_raw[P_ALU] = free_alu;
  assign free_raw[P_MUL] = free_mul;
  assign free_raw[P_LD]  = free_ld;
  assign free_raw[P_ST]  = free_st;

  // Decode each pending slot
  for (genvar k = 0; k < NSLOT; k++) begin : g_dec
    dd_decode u_dec (.ins(pins[k]), .d(dec[k]));
  end

  // Rank free stations in each pool, skipping those claimed last cycle
  for (genvar p = 0; p < NPOOL; p++) begin : g_pool
    dd_pick #(.N(NSTA)) u_pick (
      .avail(free_raw[p] & ~mask_q[p]),
      .ok1(ok1[p]), .idx1(idx1[p]), .ok2(ok2[p]), .idx2(idx2[p])
    );
  end

  // Issue decision: slot 0 older, in order
  always_comb begin
    share = pv[0] && dec[0].legal && dec[0].pooled && dec[1].pooled &&
            (dec[0].pool == dec[1].pool);
    res0  = !dec[0].pooled || ok1[dec[0].pool];
    res1  = !dec[1].pooled || (share ? ok2[dec[1].pool] : ok1[dec[1].pool]);
    go0   = pv[0] && (!dec[0].legal || (!cf_full && res0));
    done0 = !pv[0] || go0;
    go1   = pv[1] && done0 && (!dec[1].legal || (!cf_full && res1));
    iss[0] = go0 && dec[0].legal;
    iss[1] = go1 && dec[1].legal;
    sta[0] = dec[0].pooled ? idx1[dec[0].pool] : '0;
    sta[1] = !dec[1].pooled ? '0 : (share ? idx2[dec[1].pool] : idx1[dec[1].pool]);
    in_rdy = done0 && (!pv[1] || go1);
  end

  // Stations claimed this cycle
  always_comb begin
    alloc_d = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (iss[k] && dec[k].pooled) begin
        alloc_d[dec[k].pool][sta[k]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pv     <= '0;
      pins   <= '0;
      mask_q <= '0;
    end else begin
      mask_q <= alloc_d;
      if (in_rdy) begin
        pv   <= in_vld;
        pins <= in_ins;
      end else begin
        pv[0] <= pv[0] && !go0;
        pv[1] <= pv[1] && !go1;
      end
    end
  end

  // Registered instruction buses
  for (genvar k = 0; k < NSLOT; k++) begin : g_bus
    logic          b_vld;
    logic [2:0]    b_unit;
    logic [1:0]    b_fn, b_dst, b_s1, b_s2;
    logic [SW-1:0] b_sta;
    logic [15:0]   b_imm;
    logic [29:0]   b_addr;
    dd_bus_reg #(.SW(SW)) u_bus (
      .clk(clk), .rst(rst), .issue(iss[k]), .d(dec[k]), .sta(sta[k]),
      .vld(b_vld), .unit(b_unit), .fn(b_fn), .dst(b_dst), .src1(b_s1),
      .src2(b_s2), .sta_q(b_sta), .imm(b_imm), .addr(b_addr)
    );
    assign bus_vld[k]  = b_vld;
    assign bus_unit[k] = b_unit;
    assign bus_fn[k]   = b_fn;
    assign bus_dst[k]  = b_dst;
    assign bus_src1[k] = b_s1;
    assign bus_src2[k] = b_s2;
    assign bus_sta[k]  = b_sta;
    assign bus_imm[k]  = b_imm;
    assign bus_addr[k] = b_addr;
  end

  // R8: a full completion file lets nothing onto the buses
  a_r8_full_blocks_issue: assert property (@(posedge clk) disable iff (rst)
    $past(cf_full) |-> (bus_vld == 2'b00));

  // R5: two pooled instructions of one pool never share a station
  a_r5_distinct_stations: assert property (@(posedge clk) disable iff (rst)
    (bus_vld == 2'b11 && bus_unit[0] == bus_unit[1] && bus_unit[0] != 3'(U_RF))
      |-> (bus_sta[0] != bus_sta[1]));

  // R10: a station shown on a bus is not shown again in the next cycle
  for (genvar j = 0; j < NSLOT; j++) begin : g_chk_a
    for (genvar k = 0; k < NSLOT; k++) begin : g_chk_b
      a_r10_no_back_to_back_claim: assert property (@(posedge clk) disable iff (rst)
        (bus_vld[j] && bus_unit[j] != 3'(U_RF)) |=>
          !(bus_vld[k] && bus_unit[k] == $past(bus_unit[j]) && bus_sta[k] == $past(bus_sta[j])));
    end
  end
endmodule

// File: tb/tb_dual_dispatch.sv
module tb_dual_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NSTA = 2;
  localparam int SW = 1;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [1:0]           in_vld = '0;
  logic [1:0][31:0]     in_ins = '0;
  logic                 in_rdy;
  logic [NSTA-1:0]      free_alu = '1, free_mul = '1, free_ld = '1, free_st = '1;
  logic                 cf_full = 1'b0;
  logic [1:0]           bus_vld;
  logic [1:0][2:0]      bus_unit;
  logic [1:0][1:0]      bus_fn, bus_dst, bus_src1, bus_src2;
  logic [1:0][SW-1:0]   bus_sta;
  logic [1:0][15:0]     bus_imm;
  logic [1:0][29:0]     bus_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dispatch #(.NSTA(NSTA)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_ins(in_ins), .in_rdy(in_rdy),
    .free_alu(free_alu), .free_mul(free_mul), .free_ld(free_ld), .free_st(free_st),
    .cf_full(cf_full), .bus_vld(bus_vld), .bus_unit(bus_unit), .bus_fn(bus_fn),
    .bus_dst(bus_dst), .bus_src1(bus_src1), .bus_src2(bus_src2), .bus_sta(bus_sta),
    .bus_imm(bus_imm), .bus_addr(bus_addr)
  );

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] nm(logic [1:0] rs, logic [1:0] fn, logic [1:0] d,
                                     logic [1:0] a, logic [1:0] b, logic [15:0] imm);
    return {1'b0, rs, fn, d, a, b, 5'b0, imm};
  endfunction

  function automatic logic [31:0] mem(logic ld, logic [1:0] r, logic [27:0] wa);
    return {1'b1, ld, r, wa};
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Present a pair for one cycle; returns at the negedge after it was latched
  task automatic send(logic [1:0] v, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    in_vld = v; in_ins[0] = a; in_ins[1] = b;
    @(negedge clk);
    in_vld = '0;
  endtask

  task automatic t_reset();
    chk("R1 bus_vld after reset", 64'(bus_vld), 64'd0);
    chk("R1 in_rdy after reset", 64'(in_rdy), 64'd1);
  endtask

  task automatic t_alu_mul();
    idle(2);
    send(2'b11, nm(2'b00, 2'b00, 2'd1, 2'd2, 2'd3, 16'h1234),
                nm(2'b01, 2'b00, 2'd2, 2'd0, 2'd1, 16'hbeef));
    @(negedge clk);
    chk("R4 both buses valid", 64'(bus_vld), 64'h3);
    chk("R2 unit ALU", 64'(bus_unit[0]), 64'd0);
    chk("R2 fn add", 64'(bus_fn[0]), 64'd0);
    chk("R2 dst", 64'(bus_dst[0]), 64'd1);
    chk("R2 src1", 64'(bus_src1[0]), 64'd2);
    chk("R2 src2", 64'(bus_src2[0]), 64'd3);
    chk("R2 imm", 64'(bus_imm[0]), 64'h1234);
    chk("R2 unit MUL", 64'(bus_unit[1]), 64'd1);
    chk("R2 imm bus1", 64'(bus_imm[1]), 64'hbeef);
    chk("R5 ALU station 0", 64'(bus_sta[0]), 64'd0);
  endtask

  task automatic t_mem();
    logic [27:0] wa0 = 28'h0abcdef;
    logic [27:0] wa1 = 28'hfffffff;
    idle(2);
    send(2'b11, mem(1'b1, 2'd3, wa0), mem(1'b0, 2'd2, wa1));
    @(negedge clk);
    chk("R3 both valid", 64'(bus_vld), 64'h3);
    chk("R3 load unit", 64'(bus_unit[0]), 64'd3);
    chk("R3 load dst", 64'(bus_dst[0]), 64'd3);
    chk("R3 load addr", 64'(bus_addr[0]), 64'({wa0, 2'b00}));
    chk("R3 store unit", 64'(bus_unit[1]), 64'd4);
    chk("R3 store src1", 64'(bus_src1[1]), 64'd2);
    chk("R3 store addr", 64'(bus_addr[1]), 64'({wa1, 2'b00}));
  endtask

  task automatic t_two_alu();
    idle(2);
    send(2'b11, nm(2'b00, 2'b01, 2'd0, 2'd1, 2'd2, 16'h0),
                nm(2'b00, 2'b11, 2'd3, 2'd0, 2'd0, 16'h0));
    @(negedge clk);
    chk("R5 both ALU valid", 64'(bus_vld), 64'h3);
    chk("R5 older gets station 0", 64'(bus_sta[0]), 64'd0);
    chk("R5 younger gets station 1", 64'(bus_sta[1]), 64'd1);
    chk("R2 fn nor", 64'(bus_fn[0]), 64'd1);
    chk("R2 fn srl", 64'(bus_fn[1]), 64'd3);
  endtask

  task automatic t_conflict();
    idle(2);
    free_alu = 2'b10;
    @(negedge clk);
    in_vld = 2'b11;
    in_ins[0] = nm(2'b00, 2'b00, 2'd1, 2'd1, 2'd1, 16'h0011);
    in_ins[1] = nm(2'b00, 2'b10, 2'd2, 2'd3, 2'd0, 16'h0022);
    @(negedge clk);
    in_vld = '0;
    chk("R6 in_rdy low while younger held", 64'(in_rdy), 64'd0);
    @(negedge clk);
    chk("R6 only older issues", 64'(bus_vld), 64'h1);
    chk("R5 older takes only free station", 64'(bus_sta[0]), 64'd1);
    chk("R10 claimed station masked, still held", 64'(in_rdy), 64'd0);
    @(negedge clk);
    chk("R10 no issue while mask active", 64'(bus_vld), 64'h0);
    chk("R9 bus0 dst stable", 64'(bus_dst[0]), 64'd1);
    chk("R9 bus0 imm stable", 64'(bus_imm[0]), 64'h0011);
    @(negedge clk);
    chk("R6 younger issues later", 64'(bus_vld), 64'h2);
    chk("R6 younger station", 64'(bus_sta[1]), 64'd1);
    chk("R6 younger fields", 64'(bus_imm[1]), 64'h0022);
    free_alu = '1;
  endtask

  task automatic t_order();
    idle(2);
    free_mul = 2'b00;
    send(2'b11, nm(2'b01, 2'b00, 2'd1, 2'd2, 2'd3, 16'h0),
                nm(2'b00, 2'b00, 2'd0, 2'd0, 2'd0, 16'h0033));
    @(negedge clk);
    chk("R7 younger waits behind older", 64'(bus_vld), 64'h0);
    chk("R7 in_rdy low", 64'(in_rdy), 64'd0);
    free_mul = 2'b01;
    @(negedge clk);
    chk("R7 both issue after release", 64'(bus_vld), 64'h3);
    chk("R7 younger ALU station 0", 64'(bus_sta[1]), 64'd0);
    chk("R7 younger imm", 64'(bus_imm[1]), 64'h0033);
    free_mul = '1;
  endtask

  task automatic t_cf();
    idle(2);
    cf_full = 1'b1;
    send(2'b11, nm(2'b00, 2'b00, 2'd1, 2'd0, 2'd0, 16'h0),
                nm(2'b01, 2'b00, 2'd2, 2'd0, 2'd0, 16'h0));
    @(negedge clk);
    chk("R8 nothing issues when full", 64'(bus_vld), 64'h0);
    cf_full = 1'b0;
    @(negedge clk);
    chk("R8 issue resumes", 64'(bus_vld), 64'h3);
  endtask

  task automatic t_rf();
    idle(2);
    free_alu = '0; free_mul = '0; free_ld = '0; free_st = '0;
    send(2'b11, nm(2'b10, 2'b00, 2'd1, 2'd0, 2'd0, 16'h5a5a),
                nm(2'b10, 2'b01, 2'd1, 2'd0, 2'd0, 16'ha5a5));
    @(negedge clk);
    chk("R11 RF ops issue without stations", 64'(bus_vld), 64'h3);
    chk("R11 unit RF", 64'(bus_unit[1]), 64'd2);
    chk("R11 station tag 0", 64'(bus_sta[1]), 64'd0);
    chk("R2 lui fn", 64'(bus_fn[1]), 64'd1);
    chk("R2 li imm", 64'(bus_imm[0]), 64'h5a5a);
    free_alu = '1; free_mul = '1; free_ld = '1; free_st = '1;
  endtask

  task automatic t_illegal();
    idle(2);
    send(2'b11, nm(2'b11, 2'b00, 2'd3, 2'd3, 2'd3, 16'hffff),
                nm(2'b00, 2'b00, 2'd2, 2'd1, 2'd0, 16'h0044));
    @(negedge clk);
    chk("R12 reserved dropped, younger issues", 64'(bus_vld), 64'h2);
    chk("R12 younger imm", 64'(bus_imm[1]), 64'h0044);
    chk("R12 not held", 64'(in_rdy), 64'd1);
  endtask

  task automatic t_b2b();
    idle(2);
    @(negedge clk);
    chk("R4 ready before first pair", 64'(in_rdy), 64'd1);
    in_vld = 2'b11;
    in_ins[0] = nm(2'b00, 2'b00, 2'd1, 2'd0, 2'd0, 16'h0101);
    in_ins[1] = nm(2'b01, 2'b00, 2'd2, 2'd0, 2'd0, 16'h0202);
    @(negedge clk);
    chk("R4 ready for second pair", 64'(in_rdy), 64'd1);
    in_ins[0] = mem(1'b1, 2'd1, 28'h0000010);
    in_ins[1] = mem(1'b0, 2'd0, 28'h0000020);
    @(negedge clk);
    in_vld = '0;
    chk("R4 first pair valid", 64'(bus_vld), 64'h3);
    chk("R4 first pair imm", 64'(bus_imm[1]), 64'h0202);
    @(negedge clk);
    chk("R4 second pair valid", 64'(bus_vld), 64'h3);
    chk("R4 second pair load", 64'(bus_unit[0]), 64'd3);
    chk("R4 second pair store addr", 64'(bus_addr[1]), 64'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_alu_mul();
    t_mem();
    t_two_alu();
    t_conflict();
    t_order();
    t_cf();
    t_rf();
    t_illegal();
    t_b2b();
    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule